// File: doc/BRIEF.md
# Master Clock Ratio Speed Detector

This block works out which sampling-speed class an audio path runs at. It runs on the master clock and watches the frame clock, whose rate is the sample rate. It counts master clock cycles between rising frame edges. In automatic mode it sorts each period length into one of three nominal ratios:

- 512 cycles means normal speed.
- 256 cycles means double speed.
- 128 cycles means quad speed.

In manual mode the class comes straight from a 2-bit select input. The measurement keeps running in the background, so the class measured so far is ready as soon as automatic mode is switched on.

The block also reports a lock indication. After reset, lock stays low until both clocks are shown to be running. In automatic mode, lock means two consecutive periods fell into the same class. In manual mode, lock means the frame clock is present and toggling. The two clocks must share a source, but their phase does not matter: the frame clock is resynchronised inside the block before its edges are used.

Top module: `speed_class_detect`

## Requirements
- R1: In manual mode (`auto_mode`=0), `speed_class` follows `manual_sel` with the encoding 00 = normal, 01 = double, 10 = quad. Code 11 is reported as normal (00). `speed_class` never shows 11.
- R2: In automatic mode, a frame period counts the master clock cycles from one rising frame edge to the next. A period within ±TOL (default 4) of 512 gives normal (00). Within ±TOL of 256 gives double (01). Within ±TOL of 128 gives quad (10).
- R3: A period count outside every tolerance window leaves the measured class unchanged and clears the automatic lock.
- R4: In automatic mode, `locked` rises when a period lands in the same class as the period just before it. It falls when a period lands in a different class.
- R5: After reset, `locked` is 0 and the measured class is normal.
- R6: If no rising frame edge arrives for 2^CNT_W−1 master cycles (2047 by default), `locked` drops. The next rising edge only re-arms the measurement: the period that ends at it is not used.
- R7: In manual mode, `locked` is 1 once two complete frame periods have followed an arming edge, whatever their length.
- R8: The frame clock passes through two synchroniser flops. A completed period's result shows at the outputs within four master cycles of the frame rising edge that closes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; every register in the block runs on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_clk | input | 1 | Frame (sample-rate) clock, asynchronous in phase |
| auto_mode | input | 1 | 1 = class from measured ratio, 0 = class from manual_sel |
| manual_sel | input | 2 | Manual class code: 00 normal, 01 double, 10 quad, 11 normal |
| speed_class | output | 2 | Reported class: 00 normal, 01 double, 10 quad |
| locked | output | 1 | Clocks present (manual) or two agreeing periods (automatic) |

## Verification
A corrupted period counter or a wrong tolerance window would show at the ports within four master cycles of the frame edge that closes the affected period. It appears either as a wrong class or as lock staying low when it should rise.

A broken lock history shows two ways. Lock may rise after a single agreeing period. Or it may stay high across a class change or an out-of-window period.

A missing timeout leaves `locked` high long after the frame clock has stopped. A missing re-arm step makes the stale, overlong period count as the first measurement after the clock returns.

The stimulus mixes tolerance-edge periods, out-of-window lengths, mode switches and frame-clock dropouts, so each of these faults becomes visible at the first check after it occurs.

// File: rtl/spdet_pkg.sv
package spdet_pkg;
    typedef enum logic [1:0] {
        SPD_NORMAL = 2'b00,
        SPD_DOUBLE = 2'b01,
        SPD_QUAD   = 2'b10
    } speed_e;

    localparam int NUM_CLASSES = 3;

    // nominal master cycles per frame for class index i (0 normal .. 2 quad)
    function automatic int nominal_ratio(input int base, input int idx);
        return base << (NUM_CLASSES - 1 - idx);
    endfunction
endpackage

// File: rtl/fclk_sync.sv
module fclk_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.s3;

    // R8: an edge marker lasts exactly one master cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ratio_meas.sv
module ratio_meas
    import spdet_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int BASE_RATIO = 128,
    parameter int TOL        = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rise_i,
    output speed_e cls_o,
    output logic   alock_o,
    output logic   run_ok_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             armed;
        logic             pv;
        speed_e           pcls;
        speed_e           mcls;
        logic             alock;
        logic [1:0]       run;
    } meas_t;

    meas_t  meas_d, meas_q;
    logic   hit;
    speed_e hit_cls;
    int     period;

    always_comb begin
        period  = int'(meas_q.cnt) + 1;
        hit     = 1'b0;
        hit_cls = SPD_NORMAL;
        for (int i = 0; i < NUM_CLASSES; i++) begin
            if (period >= nominal_ratio(BASE_RATIO, i) - TOL &&
                period <= nominal_ratio(BASE_RATIO, i) + TOL) begin
                hit     = 1'b1;
                hit_cls = speed_e'(i[1:0]);
            end
        end
    end

    always_comb begin
        meas_d = meas_q;
        if (rise_i) begin
            meas_d.cnt = '0;
            if (!meas_q.armed) begin
                meas_d.armed = 1'b1;
            end else begin
                if (meas_q.run != 2'd2) meas_d.run = meas_q.run + 2'd1;
                if (hit) begin
                    meas_d.alock = meas_q.pv && (hit_cls == meas_q.pcls);
                    meas_d.mcls  = hit_cls;
                    meas_d.pcls  = hit_cls;
                    meas_d.pv    = 1'b1;
                end else begin
                    meas_d.alock = 1'b0;
                    meas_d.pv    = 1'b0;
                end
            end
        end else if (meas_q.cnt == CNT_MAX) begin
            meas_d.armed = 1'b0;
            meas_d.run   = 2'd0;
            meas_d.pv    = 1'b0;
            meas_d.alock = 1'b0;
        end else begin
            meas_d.cnt = meas_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meas_q      <= '0;
            meas_q.pcls <= SPD_NORMAL;
            meas_q.mcls <= SPD_NORMAL;
        end else begin
            meas_q <= meas_d;
        end
    end

    assign cls_o    = meas_q.mcls;
    assign alock_o  = meas_q.alock;
    assign run_ok_o = (meas_q.run == 2'd2);

    // R3: measured class moves only on a closing frame edge
    p_class_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rise_i |=> $stable(meas_q.mcls));
    // R4: automatic lock can only rise right after a frame edge
    p_lock_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(meas_q.alock) |-> $past(rise_i));
    // R6: a saturated counter without an edge clears lock and history
    p_timeout_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_q.cnt == CNT_MAX && !rise_i) |=> (!meas_q.alock && meas_q.run == 2'd0));
endmodule

// File: rtl/speed_class_detect.sv
module speed_class_detect
    import spdet_pkg::*;
#(
    parameter int CNT_W      = 11,
    parameter int BASE_RATIO = 128,
    parameter int TOL        = 4
) (
    input  logic       mclk,
    input  logic       rst_n,
    input  logic       frame_clk,
    input  logic       auto_mode,
    input  logic [1:0] manual_sel,
    output logic [1:0] speed_class,
    output logic       locked
);
    logic   rise;
    speed_e meas_cls;
    speed_e man_cls;
    logic   alock;
    logic   run_ok;

    fclk_sync u_sync (
        .clk     (mclk),
        .rst_n   (rst_n),
        .async_i (frame_clk),
        .rise_o  (rise)
    );

    ratio_meas #(
        .CNT_W      (CNT_W),
        .BASE_RATIO (BASE_RATIO),
        .TOL        (TOL)
    ) u_meas (
        .clk      (mclk),
        .rst_n    (rst_n),
        .rise_i   (rise),
        .cls_o    (meas_cls),
        .alock_o  (alock),
        .run_ok_o (run_ok)
    );

    always_comb begin
        unique case (manual_sel)
            2'b01:   man_cls = SPD_DOUBLE;
            2'b10:   man_cls = SPD_QUAD;
            default: man_cls = SPD_NORMAL;
        endcase
    end

    assign speed_class = auto_mode ? meas_cls : man_cls;
    assign locked      = auto_mode ? alock : run_ok;

    // R1: the unused code never reaches the output
    p_code_legal_r1: assert property (@(posedge mclk) disable iff (!rst_n)
        speed_class != 2'b11);
endmodule

// File: tb/tb_speed_class_detect.sv
`timescale 1ns/1ps
module tb_speed_class_detect;
    logic       mclk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_clk = 1'b0;
    logic       auto_mode = 1'b0;
    logic [1:0] manual_sel = 2'b00;
    logic [1:0] speed_class;
    logic       locked;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference model state
    bit       m_armed = 0;
    bit       m_pv = 0;
    bit [1:0] m_pcls = 2'b00;
    bit [1:0] m_mcls = 2'b00;
    bit       m_alock = 0;
    int       m_run = 0;
    int       prev_len = 0;

    always #10 mclk = ~mclk;

    speed_class_detect dut (
        .mclk(mclk), .rst_n(rst_n), .frame_clk(frame_clk),
        .auto_mode(auto_mode), .manual_sel(manual_sel),
        .speed_class(speed_class), .locked(locked)
    );

    function automatic int classify(input int p); // -1 = outside windows
        if (p >= 508 && p <= 516) return 0;
        if (p >= 252 && p <= 260) return 1;
        if (p >= 124 && p <= 132) return 2;
        return -1;
    endfunction

    function automatic bit [1:0] man_map(input bit [1:0] s);
        return (s == 2'b11) ? 2'b00 : s;
    endfunction

    function automatic bit [1:0] exp_speed();
        return auto_mode ? m_mcls : man_map(manual_sel);
    endfunction

    function automatic bit exp_locked();
        return auto_mode ? m_alock : (m_run == 2);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string req);
        check({req, " speed"}, speed_class, exp_speed());
        check({req, " locked"}, locked, exp_locked());
    endtask

    task automatic model_edge();
        int c;
        if (!m_armed) begin
            m_armed = 1;
        end else begin
            if (m_run < 2) m_run++;
            c = classify(prev_len);
            if (c >= 0) begin
                m_alock = m_pv && (c[1:0] == m_pcls);
                m_mcls = c[1:0];
                m_pcls = c[1:0];
                m_pv = 1;
            end else begin
                m_alock = 0;
                m_pv = 0;
            end
        end
    endtask

    // one frame period of p master cycles; checks result of the previous one
    task automatic one_period(input int p, input string req);
        @(negedge mclk) frame_clk = 1'b1;
        model_edge();
        repeat (4) @(negedge mclk);
        check_outputs(req);
        repeat (p / 2 - 4) @(negedge mclk);
        frame_clk = 1'b0;
        repeat (p - p / 2 - 1) @(negedge mclk);
        prev_len = p;
    endtask

    task automatic dropout(input int n);
        @(negedge mclk) frame_clk = 1'b0;
        repeat (n) @(negedge mclk);
        m_armed = 0; m_run = 0; m_pv = 0; m_alock = 0;
        check_outputs("R6 dropout");
    endtask

    initial begin
        repeat (200000) @(posedge mclk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge mclk);
        rst_n = 1'b1;
        @(negedge mclk);
        check_outputs("R5 reset manual");
        auto_mode = 1'b1;
        @(negedge mclk);
        check_outputs("R5 reset auto");

        // R1 manual codes including 11
        auto_mode = 1'b0;
        for (int s = 0; s < 4; s++) begin
            manual_sel = s[1:0];
            @(negedge mclk);
            check_outputs("R1 manual code");
        end

        // R2/R4 automatic: arm, first, agreeing second
        auto_mode = 1'b1;
        one_period(512, "R2 arm");
        one_period(512, "R2 normal first");
        one_period(508, "R4 normal lock");
        one_period(516, "R4 normal hold");
        one_period(256, "R4 double drops");
        one_period(260, "R2 double relock");
        one_period(124, "R4 quad drops");
        one_period(132, "R2 quad lock");
        one_period(133, "R2 quad edge");
        one_period(300, "R3 outside window");
        one_period(128, "R3 class held");
        // R7 manual lock on nonstandard lengths
        auto_mode = 1'b0;
        manual_sel = 2'b10;
        one_period(384, "R7 any length");
        one_period(384, "R7 manual locked");
        auto_mode = 1'b1;
        @(negedge mclk);
        check_outputs("R3 auto after odd ratio");

        // R6 dropout and re-arm
        dropout(2200);
        one_period(512, "R6 re-arm");
        one_period(512, "R6 first after return");
        one_period(512, "R6 relocked");

        // constrained random
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 60; i++) begin
            int k, p;
            k = $urandom_range(0, 5);
            if (k < 3) p = (512 >> k) + $urandom_range(0, 8) - 4;
            else if (k == 3) p = 384 + $urandom_range(0, 40) - 20;
            else p = (512 >> $urandom_range(0, 2)) + 5 + $urandom_range(0, 3);
            if ($urandom_range(0, 7) == 0) auto_mode = ~auto_mode;
            manual_sel = $urandom_range(0, 3);
            if ($urandom_range(0, 29) == 0) dropout(2100);
            one_period(p, "R2 random");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule